// File: doc/BRIEF.md
# Burst Configuration and Initial-Latency Controller

This block keeps the burst configuration word of a synchronous burst-read memory and times the first word of each burst. It watches the host's write cycles for a three-write unlock-and-load command. When the third write of that command is accepted, the block stores the seven address bits 18 to 12 carried on that write.

After the address-valid strobe is released, the block counts clock edges. It raises a data-valid flag once the programmed initial latency has elapsed. It also drives a ready handshake to the host, either together with the data or one cycle before it, depending on the stored configuration. The stored burst-mode code is passed on to the address sequencer.

A burst is the period from the release of the active-low strobe `avd_n` until that strobe is driven low again. Edge 1 is the first rising clock edge that samples `avd_n` high after a rising edge that sampled it low. The ready output goes high only while `oe_n` is low.

Top module: `burst_latency_ctrl`

## Requirements
- R1: After reset, `burst_mode` is 000, `rdy` and `data_valid` are low, the latency is 7 edges and ready timing is aligned with the data. The stored configuration word is 0000011.
- R2: A write of AAh at address 555h, then 55h at address 2AAh, then C0h at address 555h loads the configuration. Only address bits 11:0 are compared. The third write stores `wr_addr[18:12]`, and the new value shows on outputs from the next cycle.
- R3: A write that does not match the expected step of the sequence returns the decoder to idle. A C0h write at 555h that follows such a mismatch leaves the configuration unchanged.
- R4: Configuration bits 14:12 (word bits 2:0) select the latency. Codes 000, 001, 010 and 011 make `data_valid` go high after edge 4, 5, 6 and 7. It then stays high until the strobe goes low.
- R5: Wait codes 100 to 111 are stored, but the latency is 7 edges.
- R6: With configuration bit 18 (word bit 6) set to 1, `rdy` goes high one edge before `data_valid`. With that bit at 0, `rdy` goes high together with `data_valid`.
- R7: While `oe_n` is high, `rdy` stays low even after the latency has expired. `rdy` rises in the cycle in which `oe_n` goes low.
- R8: A rising edge that samples `avd_n` low ends the burst: `data_valid` and `rdy` are low after that edge.
- R9: `burst_mode` equals configuration bits 17:15 (word bits 5:3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset to defaults |
| wr_en | input | 1 | One host write accepted on this edge |
| wr_addr | input | 19 | Write address |
| wr_data | input | 8 | Write data |
| avd_n | input | 1 | Address-valid strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| burst_mode | output | 3 | Stored burst-mode code for the address sequencer |
| data_valid | output | 1 | First and later burst words are valid |
| rdy | output | 1 | Ready handshake to the host |

## Verification
Two functions can coincide in one cycle: a configuration write can land while a burst count is in progress, and the strobe can be released on the same edge that completes a command. The random phase drives writes, strobe pulses and output-enable changes independently on every cycle, so these collisions occur often. Each cycle the bench compares `rdy`, `data_valid` and `burst_mode` against a model that takes the latency from the configuration value in force at that moment. Directed runs then pin down each latency code, the early-ready option, a late output enable and an aborted burst.

// File: rtl/burst_latency_ctrl.sv
module burst_latency_ctrl #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8,
  parameter logic [6:0] CFG_RESET = 7'b0000011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              avd_n,
  input  logic              oe_n,
  output logic [2:0]        burst_mode,
  output logic              data_valid,
  output logic              rdy
);

  localparam logic [11:0] ADDR_A = 12'h555;
  localparam logic [11:0] ADDR_B = 12'h2AA;
  localparam logic [2:0]  CNT_MAX = 3'd7;

  typedef enum logic [1:0] {S_IDLE, S_ONE, S_TWO} seq_t;

  seq_t       seq;
  logic [6:0] cfg;
  logic       avd_q, busy;
  logic [2:0] cnt, lat, lat_rdy;
  logic       hit1, hit2, hit3;

  assign hit1 = wr_addr[11:0] == ADDR_A && wr_data == DATA_W'(8'hAA);
  assign hit2 = wr_addr[11:0] == ADDR_B && wr_data == DATA_W'(8'h55);
  assign hit3 = wr_addr[11:0] == ADDR_A && wr_data == DATA_W'(8'hC0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq <= S_IDLE;
      cfg <= CFG_RESET;
    end else if (wr_en) begin
      case (seq)
        S_IDLE:  seq <= hit1 ? S_ONE : S_IDLE;
        S_ONE:   seq <= hit2 ? S_TWO : S_IDLE;
        default: begin
          seq <= S_IDLE;
          if (hit3) cfg <= wr_addr[18:12];
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      avd_q <= 1'b1;
      busy  <= 1'b0;
      cnt   <= '0;
    end else begin
      avd_q <= avd_n;
      if (!avd_n) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else if (!avd_q) begin
        busy <= 1'b1;
        cnt  <= 3'd1;
      end else if (busy && cnt != CNT_MAX) begin
        cnt <= cnt + 3'd1;
      end
    end
  end

  assign lat        = cfg[2] ? CNT_MAX : 3'd4 + {1'b0, cfg[1:0]};
  assign lat_rdy    = cfg[6] ? lat - 3'd1 : lat;
  assign burst_mode = cfg[5:3];
  assign data_valid = busy && cnt >= lat;
  assign rdy        = busy && !oe_n && cnt >= lat_rdy;

  assert_cfg_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && seq == S_TWO && hit3) |=> cfg == $past(wr_addr[18:12]));

  assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && seq == S_TWO) |=> $stable(cfg));

  assert_first_edge_not_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!avd_q && avd_n) |=> !data_valid);

  assert_valid_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid && avd_n && $stable(cfg)) |=> data_valid || !$stable(cfg));

  assert_reserved_lat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[2] && busy && cnt < CNT_MAX) |-> !data_valid);

  assert_early_rdy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[6] && !oe_n && busy && cnt == lat - 3'd1) |-> rdy && !data_valid);

  assert_rdy_with_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg[6] && rdy) |-> data_valid);

  assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !avd_n |=> !data_valid && !rdy);

endmodule

// File: tb/test_burst_latency_ctrl.sv
module test_burst_latency_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [18:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic avd_n = 1'b1;
  logic oe_n = 1'b1;
  logic [2:0] burst_mode;
  logic data_valid, rdy;

  int checks = 0, fails = 0;
  int m_seq = 0;
  logic [6:0] m_cfg = 7'b0000011;
  logic m_prev = 1'b1, m_busy = 1'b0;
  int m_edges = 0;
  bit done = 0;

  always #5 clk = ~clk;

  burst_latency_ctrl i_burst_latency_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .avd_n(avd_n), .oe_n(oe_n), .burst_mode(burst_mode), .data_valid(data_valid), .rdy(rdy));

  function automatic int exp_lat(input logic [6:0] c);
    return c[2] ? 7 : 4 + int'(c[1:0]);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d time=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_update();
    if (wr_en) begin
      case (m_seq)
        0: m_seq = (wr_addr[11:0] == 12'h555 && wr_data == 8'hAA) ? 1 : 0;
        1: m_seq = (wr_addr[11:0] == 12'h2AA && wr_data == 8'h55) ? 2 : 0;
        default: begin
          if (wr_addr[11:0] == 12'h555 && wr_data == 8'hC0) m_cfg = wr_addr[18:12];
          m_seq = 0;
        end
      endcase
    end
    if (!avd_n) begin m_busy = 0; m_edges = 0; end
    else if (!m_prev) begin m_busy = 1; m_edges = 1; end
    else if (m_busy) m_edges++;
    m_prev = avd_n;
  endtask

  task automatic compare();
    int l = exp_lat(m_cfg);
    int lr = m_cfg[6] ? l - 1 : l;
    check("R4 data_valid", int'(data_valid), int'(m_busy && m_edges >= l));
    check("R6 rdy", int'(rdy), int'(m_busy && !oe_n && m_edges >= lr));
    check("R9 burst_mode", int'(burst_mode), int'(m_cfg[5:3]));
  endtask

  task automatic step(input logic a, input logic o, input logic w,
                      input logic [18:0] ad, input logic [7:0] d);
    avd_n = a; oe_n = o; wr_en = w; wr_addr = ad; wr_data = d;
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare();
  endtask

  task automatic cfg_write(input logic [6:0] code);
    step(1, 1, 1, {7'h15, 12'h555}, 8'hAA);
    step(1, 1, 1, {7'h6A, 12'h2AA}, 8'h55);
    step(1, 1, 1, {code, 12'h555}, 8'hC0);
    step(1, 1, 0, '0, '0);
  endtask

  task automatic measure(input int exp_dv, input int exp_rdy, input string tag);
    int fdv = 0, frdy = 0;
    step(0, 0, 0, '0, '0);
    for (int k = 1; k <= 10; k++) begin
      step(1, 0, 0, '0, '0);
      if (data_valid && fdv == 0) fdv = k;
      if (rdy && frdy == 0) frdy = k;
    end
    check({tag, " first data_valid edge"}, fdv, exp_dv);
    check({tag, " first rdy edge"}, frdy, exp_rdy);
    step(0, 1, 0, '0, '0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    check("R1 reset burst_mode", int'(burst_mode), 0);
    check("R1 reset rdy", int'(rdy), 0);
    check("R1 reset data_valid", int'(data_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    measure(7, 7, "R1 default latency");

    for (int c = 0; c < 4; c++) begin
      cfg_write({1'b0, 3'b010, 3'(c)});
      check("R2 burst_mode after load", int'(burst_mode), 2);
      measure(4 + c, 4 + c, "R4 wait code");
    end
    cfg_write(7'b0_011_101);
    measure(7, 7, "R5 reserved code");
    cfg_write(7'b0_100_110);
    check("R9 burst_mode", int'(burst_mode), 4);
    measure(7, 7, "R5 reserved code 110");

    cfg_write(7'b1_001_001);
    measure(5, 4, "R6 early ready");
    cfg_write(7'b0_001_001);
    measure(5, 5, "R6 ready with data");

    step(1, 1, 1, {7'h00, 12'h555}, 8'hAA);
    step(1, 1, 1, {7'h00, 12'h2AB}, 8'h55);
    step(1, 1, 1, {7'b0_111_000, 12'h555}, 8'hC0);
    step(1, 1, 0, '0, '0);
    check("R3 mismatch leaves burst_mode", int'(burst_mode), 1);
    measure(5, 5, "R3 mismatch leaves latency");

    step(0, 1, 0, '0, '0);
    for (int k = 1; k <= 9; k++) step(1, 1, 0, '0, '0);
    check("R7 rdy held while oe_n high", int'(rdy), 0);
    check("R7 data_valid while oe_n high", int'(data_valid), 1);
    step(1, 0, 0, '0, '0);
    check("R7 rdy after oe_n low", int'(rdy), 1);

    step(1, 0, 0, '0, '0);
    step(0, 0, 0, '0, '0);
    check("R8 abort data_valid", int'(data_valid), 0);
    check("R8 abort rdy", int'(rdy), 0);

    for (int n = 0; n < 4000; n++) begin
      logic a, o, w;
      logic [18:0] ad;
      logic [7:0] d;
      a = ($urandom % 12) != 0;
      o = ($urandom % 4) == 0;
      w = ($urandom % 3) == 0;
      ad = 19'($urandom);
      d = 8'($urandom);
      if (w && ($urandom % 10) < 7) begin
        case (m_seq)
          0: begin ad[11:0] = 12'h555; d = 8'hAA; end
          1: begin ad[11:0] = 12'h2AA; d = 8'h55; end
          default: begin ad[11:0] = 12'h555; d = 8'hC0; end
        endcase
      end
      step(a, o, w, ad, d);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule